// File: doc/BRIEF.md
# Pseudo-SRAM Asynchronous Command Decoder

This block is the control front end of a pseudo-static RAM running in its SRAM-style asynchronous mode. A fast system clock oversamples the active-low pins: chip select, address-valid, write-enable, output-enable and the two byte enables. It also samples the control-register-enable pin, the device clock pin and the address and data buses. Every sampled pin passes through a two-flop synchronizer. The decoder then classifies the pins as a read, write, register load, no-operation, deselect or deep power-down. Rising edges of the control strobes are found by comparing the current sample with the previous one.

A small word memory stands in for the array. Reads drive only the enabled byte lanes. A write is committed once, on the first rising edge among chip select, write-enable and the two byte enables, using the pin values seen just before that edge. The two configuration registers are loaded from the address pins. Address bit 19 picks the refresh register (low) or the bus register (high). A load is accepted only when the register access did not follow directly on a read or write. Deep power-down is entered when the chip is deselected while refresh-register bit 4 is 0. It stays set until that bit is written back to 1.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, the command output shows deselect and no byte lane is enabled. The refresh register reads 16'h0010 and the bus register reads 16'h8000. The mode output shows asynchronous mode, which is bus-register bit 15 equal to 1.
- R2: Chip select, address-valid and output-enable low, with write-enable high and register-enable low, decode as a read. The addressed word then appears on the data output with its lane enables set.
- R3: Chip select, address-valid and write-enable low, with register-enable low and at least one byte enable low, decode as a write whatever the level of output-enable. No lane is driven during a write.
- R4: The upper byte enable controls bits 15..8 (lane enable bit 1) and the lower one controls bits 7..0 (lane enable bit 0). On a read, a disabled lane outputs zero with its enable low. On a write, a disabled lane keeps its stored byte.
- R5: Write data is stored once, at the first rising edge among chip select, write-enable, upper and lower byte enable. Lanes, address and data are the values sampled just before that edge, and later edges of the same write store nothing.
- R6: With register-enable high and chip select, address-valid and write-enable low, the command is a register load. A rise of chip select or write-enable stores address bits 15..0 into the refresh register if address bit 19 is 0, or into the bus register if it is 1.
- R7: A register load entered directly from a read or write, with no other command between, is ignored and both registers keep their values.
- R8: Chip select high decodes as deselect, and chip select low with write-enable and output-enable high decodes as no-operation. Both keep every lane disabled and the data output zero, and neither changes the stored data.
- R9: Chip select high while refresh-register bit 4 is 0 enters deep power-down. The command output then shows power-down, and reads and writes are blocked. The state ends only after a register load that sets refresh-register bit 4 to 1, which must be allowed while in power-down.
- R10: The clock-error output is 1 when the device clock pin is sampled high while bus-register bit 15 is 1, and 0 otherwise.
- R11: The command output is one-hot: bit 0 read, bit 1 write, bit 2 register load, bit 3 no-operation, bit 4 deselect, bit 5 power-down. Outputs settle no more than 4 system clocks after the pins change.
- R12: A chip-selected combination outside the supported set reports no-operation and raises the illegal-command output. Examples are a read or write with address-valid high or with both byte enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| memClk | input | 1 | Device clock pin, must stay low in asynchronous mode |
| csN | input | 1 | Chip select, active low |
| advN | input | 1 | Address valid, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| ubN | input | 1 | Upper byte enable, active low |
| lbN | input | 1 | Lower byte enable, active low |
| cre | input | 1 | Control register enable, active high |
| addr | input | 21 | Address bus, also the register payload |
| dqIn | input | 16 | Data bus as driven by the host |
| dqOut | output | 16 | Read data, zero on disabled lanes |
| dqOe | output | 2 | Lane drive enables, bit 1 upper, bit 0 lower |
| cmdOneHot | output | 6 | Decoded command, one-hot |
| illegalCmd | output | 1 | Unsupported pin combination seen |
| dpdActive | output | 1 | Deep power-down in effect |
| clkError | output | 1 | Device clock high during asynchronous mode |
| asyncMode | output | 1 | Bus-register bit 15 |
| rcrValue | output | 16 | Refresh configuration register |
| bcrValue | output | 16 | Bus configuration register |

## Verification
The bench uses the default parameters: 21 address bits, 16 data bits, a 16-word memory, the register-select bit at 19 and the power-down bit at 4. At these sizes the bench can write three separate addresses and read them back. It can also place register payloads with bit 19 set and cleared and drive the power-down bit both ways. Holding the pins for five system clocks per step puts every result past the synchronizer and output registers. The corner cases covered are byte-enable release ahead of write-enable, a register load straight after a read, and power-down entry and exit.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int CMD_N = 6;

  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_SETREG = 3'd2,
    CMD_NOP    = 3'd3,
    CMD_DESEL  = 3'd4,
    CMD_DPD    = 3'd5
  } cmdIdx_e;

  typedef struct packed {
    logic       readEn;
    logic [1:0] readLanes;
    logic       writeStb;
    logic [1:0] writeLanes;
    logic       regStb;
  } strobe_t;

endpackage

// File: rtl/psram_sync.sv
module psram_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               advN,
  input  logic               weN,
  input  logic               oeN,
  input  logic               ubN,
  input  logic               lbN,
  input  logic               cre,
  input  logic               memClk,
  input  logic               rcrDpdOff,
  input  logic               asyncMode,
  output strobe_t            stb,
  output logic [CMD_N-1:0]   cmdOneHot,
  output logic               illegalCmd,
  output logic               dpdActive,
  output logic               clkError
);
  cmdIdx_e cmdNow, cmdReg;
  logic    illNow;
  logic    csP, weP, ubP, lbP;
  logic    riseCs, riseWe, riseUb, riseLb;
  logic    writeDone, regOk, regPat, laneAny, capture;

  assign regPat  = !csN && !advN && !weN && cre;
  assign laneAny = !ubN || !lbN;

  always_comb begin
    cmdNow = CMD_NOP;
    illNow = 1'b0;
    if (csN && !dpdActive)          cmdNow = CMD_DESEL;
    else if (dpdActive && !regPat)  cmdNow = CMD_DPD;
    else if (regPat)                cmdNow = CMD_SETREG;
    else if (!weN) begin
      if (!advN && !cre && laneAny) cmdNow = CMD_WRITE;
      else                          illNow = 1'b1;
    end else if (!oeN) begin
      if (!advN && !cre && laneAny) cmdNow = CMD_READ;
      else                          illNow = 1'b1;
    end
  end

  assign riseCs = csN && !csP;
  assign riseWe = weN && !weP;
  assign riseUb = ubN && !ubP;
  assign riseLb = lbN && !lbP;

  assign capture = (cmdReg == CMD_WRITE) && !writeDone &&
                   (riseCs || riseWe || riseUb || riseLb);

  always_comb begin
    stb            = '0;
    stb.readEn     = (cmdNow == CMD_READ);
    stb.readLanes  = {!ubN, !lbN};
    stb.writeStb   = capture;
    stb.writeLanes = {!ubP, !lbP};
    stb.regStb     = (cmdReg == CMD_SETREG) && regOk && (riseCs || riseWe);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csP        <= 1'b1;
      weP        <= 1'b1;
      ubP        <= 1'b1;
      lbP        <= 1'b1;
      cmdReg     <= CMD_DESEL;
      illegalCmd <= 1'b0;
      writeDone  <= 1'b0;
      regOk      <= 1'b0;
      dpdActive  <= 1'b0;
      clkError   <= 1'b0;
    end else begin
      csP        <= csN;
      weP        <= weN;
      ubP        <= ubN;
      lbP        <= lbN;
      cmdReg     <= cmdNow;
      illegalCmd <= illNow;
      clkError   <= memClk && asyncMode;
      if (capture)                 writeDone <= (cmdNow == CMD_WRITE);
      else if (cmdNow != CMD_WRITE) writeDone <= 1'b0;
      if (cmdNow == CMD_SETREG && cmdReg != CMD_SETREG)
        regOk <= !(cmdReg == CMD_READ || cmdReg == CMD_WRITE);
      if (dpdActive) dpdActive <= !rcrDpdOff;
      else           dpdActive <= csN && !rcrDpdOff;
    end
  end

  assign cmdOneHot = CMD_N'(1) << cmdReg;
endmodule

// File: rtl/psram_datapath.sv
module psram_datapath
  import psram_pkg::*;
#(
  parameter int          ADDR_W      = 21,
  parameter int          DATA_W      = 16,
  parameter int          MEM_AW      = 4,
  parameter int          REG_SEL_BIT = 19,
  parameter int          DPD_BIT     = 4,
  parameter int          MODE_BIT    = 15,
  parameter logic [15:0] RCR_RESET   = 16'h0010,
  parameter logic [15:0] BCR_RESET   = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dqS,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] dqOut,
  output logic [1:0]        dqOe,
  output logic [15:0]       rcrValue,
  output logic [15:0]       bcrValue,
  output logic              rcrDpdOff,
  output logic              asyncMode
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << MEM_AW;

  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevDq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
      prevDq   <= '0;
      rcrValue <= RCR_RESET;
      bcrValue <= BCR_RESET;
    end else begin
      prevAddr <= addrS;
      prevDq   <= dqS;
      if (stb.regStb) begin
        if (prevAddr[REG_SEL_BIT]) bcrValue <= prevAddr[15:0];
        else                       rcrValue <= prevAddr[15:0];
      end
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
        dqOut[ln*LANE_W +: LANE_W] <= '0;
        dqOe[ln]                   <= 1'b0;
      end else begin
        if (stb.writeStb && stb.writeLanes[ln])
          laneMem[prevAddr[MEM_AW-1:0]] <= prevDq[ln*LANE_W +: LANE_W];
        if (stb.readEn && stb.readLanes[ln]) begin
          dqOut[ln*LANE_W +: LANE_W] <= laneMem[addrS[MEM_AW-1:0]];
          dqOe[ln]                   <= 1'b1;
        end else begin
          dqOut[ln*LANE_W +: LANE_W] <= '0;
          dqOe[ln]                   <= 1'b0;
        end
      end
    end
  end

  assign rcrDpdOff = rcrValue[DPD_BIT];
  assign asyncMode = bcrValue[MODE_BIT];

  logic unusedAddrBits;
  assign unusedAddrBits = ^{prevAddr[ADDR_W-1:REG_SEL_BIT+1],
                            prevAddr[REG_SEL_BIT-1:16],
                            addrS[ADDR_W-1:MEM_AW]};
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memClk,
  input  logic              csN,
  input  logic              advN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              ubN,
  input  logic              lbN,
  input  logic              cre,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [1:0]        dqOe,
  output logic [CMD_N-1:0]  cmdOneHot,
  output logic              illegalCmd,
  output logic              dpdActive,
  output logic              clkError,
  output logic              asyncMode,
  output logic [15:0]       rcrValue,
  output logic [15:0]       bcrValue
);
  localparam int CTL_W = 8;
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [CTL_W-1:0]  ctlS;
  logic [BUS_W-1:0]  busS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dqS;
  strobe_t           stb;
  logic              rcrDpdOff;

  psram_sync #(.W(CTL_W), .RST_VAL(8'b0011_1111)) u_ctlSync (
    .clk(clk), .rstN(rstN),
    .d({memClk, cre, lbN, ubN, oeN, weN, advN, csN}),
    .q(ctlS)
  );

  psram_sync #(.W(BUS_W), .RST_VAL('0)) u_busSync (
    .clk(clk), .rstN(rstN), .d({addr, dqIn}), .q(busS)
  );

  assign {addrS, dqS} = busS;

  psram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csN(ctlS[0]), .advN(ctlS[1]), .weN(ctlS[2]), .oeN(ctlS[3]),
    .ubN(ctlS[4]), .lbN(ctlS[5]), .cre(ctlS[6]), .memClk(ctlS[7]),
    .rcrDpdOff(rcrDpdOff), .asyncMode(asyncMode),
    .stb(stb), .cmdOneHot(cmdOneHot), .illegalCmd(illegalCmd),
    .dpdActive(dpdActive), .clkError(clkError)
  );

  psram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .addrS(addrS), .dqS(dqS), .stb(stb),
    .dqOut(dqOut), .dqOe(dqOe), .rcrValue(rcrValue), .bcrValue(bcrValue),
    .rcrDpdOff(rcrDpdOff), .asyncMode(asyncMode)
  );
endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] dqOut,
  input logic [1:0]  dqOe,
  input logic [5:0]  cmdOneHot,
  input logic        illegalCmd,
  input logic        dpdActive,
  input logic        clkError,
  input logic        asyncMode
);
  assert_onehot_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmdOneHot) == 1);

  assert_lane_only_on_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe != 2'b00) |-> cmdOneHot[0]);

  assert_upper_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe[1] |-> (dqOut[15:8] == 8'h00));

  assert_lower_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe[0] |-> (dqOut[7:0] == 8'h00));

  assert_dpd_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpdActive |-> (dqOe == 2'b00));

  assert_dpd_from_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpdActive) |-> cmdOneHot[4]);

  assert_illegal_is_nop_R12: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> cmdOneHot[3]);

  assert_clkerr_async_R10: assert property (@(posedge clk) disable iff (!rstN)
    clkError |-> $past(asyncMode));
endmodule

bind psram_async_ctrl psram_async_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .dqOut(dqOut), .dqOe(dqOe), .cmdOneHot(cmdOneHot),
  .illegalCmd(illegalCmd), .dpdActive(dpdActive), .clkError(clkError),
  .asyncMode(asyncMode)
);

// File: tb/psram_async_ctrl_tb.sv
module psram_async_ctrl_tb;
  localparam logic [5:0] C_RD = 6'd1, C_WR = 6'd2, C_SR = 6'd4,
                         C_NOP = 6'd8, C_DES = 6'd16, C_DPD = 6'd32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic memClk = 1'b0, csN = 1'b1, advN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic ubN = 1'b1, lbN = 1'b1, cre = 1'b0;
  logic [20:0] addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut, rcrValue, bcrValue;
  logic [1:0]  dqOe;
  logic [5:0]  cmdOneHot;
  logic        illegalCmd, dpdActive, clkError, asyncMode;

  psram_async_ctrl u_dut (
    .clk(clk), .rstN(rstN), .memClk(memClk), .csN(csN), .advN(advN),
    .weN(weN), .oeN(oeN), .ubN(ubN), .lbN(lbN), .cre(cre), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .cmdOneHot(cmdOneHot),
    .illegalCmd(illegalCmd), .dpdActive(dpdActive), .clkError(clkError),
    .asyncMode(asyncMode), .rcrValue(rcrValue), .bcrValue(bcrValue)
  );

  typedef struct {
    string       req;
    logic [5:0]  cmd;
    logic [1:0]  oe;
    logic [15:0] dout;
    logic        ill, dpd, cerr, asy;
    logic [15:0] rcr, bcr;
  } exp_t;

  exp_t q[$];
  event sampleEv;
  int   nRun = 0, nFail = 0;
  bit   finished = 1'b0;

  logic [15:0] mRcr = 16'h0010, mBcr = 16'h8000;
  logic        mDpd = 1'b0, mAsy = 1'b1;

  task automatic drive(input logic c, a, w, o, u, l, r,
                       input logic [20:0] ad, input logic [15:0] d);
    @(negedge clk);
    csN = c; advN = a; weN = w; oeN = o; ubN = u; lbN = l; cre = r;
    addr = ad; dqIn = d;
    repeat (5) @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [5:0] cmd,
                            input logic [1:0] oe, input logic [15:0] dout,
                            input logic ill, input logic cerr);
    exp_t it;
    it.req = req; it.cmd = cmd; it.oe = oe; it.dout = dout; it.ill = ill;
    it.dpd = mDpd; it.cerr = cerr; it.asy = mAsy; it.rcr = mRcr; it.bcr = mBcr;
    q.push_back(it);
    ->sampleEv;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        nRun++;
        if (cmdOneHot !== e.cmd || dqOe !== e.oe || dqOut !== e.dout ||
            illegalCmd !== e.ill || dpdActive !== e.dpd || clkError !== e.cerr ||
            asyncMode !== e.asy || rcrValue !== e.rcr || bcrValue !== e.bcr) begin
          nFail++;
          $display("FAIL %s: actual cmd=%h oe=%b dout=%h ill=%b dpd=%b cerr=%b asy=%b rcr=%h bcr=%h expected cmd=%h oe=%b dout=%h ill=%b dpd=%b cerr=%b asy=%b rcr=%h bcr=%h",
                   e.req, cmdOneHot, dqOe, dqOut, illegalCmd, dpdActive, clkError,
                   asyncMode, rcrValue, bcrValue, e.cmd, e.oe, e.dout, e.ill,
                   e.dpd, e.cerr, e.asy, e.rcr, e.bcr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun + 1, nFail);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle();
    expect_out("R1 reset state", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);

    @(negedge clk); memClk = 1'b1; settle();
    expect_out("R10 clock high in async mode", C_DES, 2'b00, 16'h0, 1'b0, 1'b1);
    @(negedge clk); memClk = 1'b0; settle();
    expect_out("R10 clock low", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);

    drive(0, 0, 0, 0, 0, 0, 0, 21'h3, 16'hA5C3);
    expect_out("R3 write with oe low ignored", C_WR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 0, 0, 0, 21'h3, 16'h0000);
    expect_out("R2 R5 read back after we rise", C_RD, 2'b11, 16'hA5C3, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    expect_out("R8 deselect", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);

    drive(0, 0, 0, 1, 0, 0, 0, 21'h5, 16'h1111);
    expect_out("R3 full write", C_WR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    drive(0, 0, 0, 1, 1, 0, 0, 21'h5, 16'h22EE);
    expect_out("R4 lower-only write", C_WR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    drive(0, 0, 1, 0, 0, 1, 0, 21'h5, 16'h0);
    expect_out("R4 upper-only read", C_RD, 2'b10, 16'h1100, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 1, 0, 0, 21'h5, 16'h0);
    expect_out("R4 lower-only read", C_RD, 2'b01, 16'h00EE, 1'b0, 1'b0);
    drive(0, 0, 1, 1, 0, 0, 0, 21'h5, 16'h0);
    expect_out("R8 no-operation", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 0, 0, 0, 21'h5, 16'h0);
    expect_out("R8 data intact after nop", C_RD, 2'b11, 16'h11EE, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);

    drive(0, 0, 0, 1, 0, 0, 0, 21'h6, 16'h3C3C);
    drive(0, 0, 0, 1, 1, 0, 0, 21'h6, 16'hFFFF);
    expect_out("R5 write continues after ub rise", C_WR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 0, 1, 1, 1, 0, 21'h6, 16'hFFFF);
    expect_out("R12 write with no lanes", C_NOP, 2'b00, 16'h0, 1'b1, 1'b0);
    drive(0, 0, 1, 1, 1, 1, 0, 21'h6, 16'hFFFF);
    expect_out("R8 legal nop", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 0, 0, 0, 21'h6, 16'h0);
    expect_out("R5 first edge data kept", C_RD, 2'b11, 16'h3C3C, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);

    drive(0, 1, 1, 0, 0, 0, 0, 21'h3, 16'h0);
    expect_out("R12 read with adv high", C_NOP, 2'b00, 16'h0, 1'b1, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);

    drive(0, 0, 0, 1, 1, 1, 1, 21'h000055, 16'h0);
    expect_out("R6 register load decoded", C_SR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 1, 1, 1, 1, 21'h000055, 16'h0);
    mRcr = 16'h0055;
    expect_out("R6 refresh register loaded", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);

    drive(0, 0, 1, 0, 0, 0, 0, 21'h3, 16'h0);
    expect_out("R2 read before busy load", C_RD, 2'b11, 16'hA5C3, 1'b0, 1'b0);
    drive(0, 0, 0, 0, 0, 0, 1, 21'h0000AA, 16'h0);
    expect_out("R7 load straight after read", C_SR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 1, 0, 0, 1, 21'h0000AA, 16'h0);
    expect_out("R7 busy load ignored", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);

    drive(0, 0, 0, 1, 1, 1, 1, 21'h081234, 16'h0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    mBcr = 16'h1234; mAsy = 1'b0;
    expect_out("R6 bus register loaded by cs rise", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);
    @(negedge clk); memClk = 1'b1; settle();
    expect_out("R10 clock high outside async mode", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);
    @(negedge clk); memClk = 1'b0; settle();

    drive(0, 0, 0, 1, 1, 1, 1, 21'h000000, 16'h0);
    drive(0, 0, 1, 1, 1, 1, 1, 21'h000000, 16'h0);
    mRcr = 16'h0000;
    expect_out("R9 armed but still selected", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    mDpd = 1'b1;
    expect_out("R9 enters power-down", C_DPD, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 0, 0, 0, 21'h3, 16'h0);
    expect_out("R9 read blocked", C_DPD, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 0, 1, 0, 0, 0, 21'h3, 16'hFFFF);
    expect_out("R9 write blocked", C_DPD, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    drive(0, 0, 0, 1, 1, 1, 1, 21'h000010, 16'h0);
    expect_out("R9 register load allowed in power-down", C_SR, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 1, 1, 1, 1, 21'h000010, 16'h0);
    mRcr = 16'h0010; mDpd = 1'b0;
    expect_out("R9 power-down cleared", C_NOP, 2'b00, 16'h0, 1'b0, 1'b0);
    drive(0, 0, 1, 0, 0, 0, 0, 21'h3, 16'h0);
    expect_out("R9 blocked write left data", C_RD, 2'b11, 16'hA5C3, 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1, 1, 0, 21'h0, 16'h0);
    expect_out("R8 final deselect", C_DES, 2'b00, 16'h0, 1'b0, 1'b0);

    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule